// File: doc/BRIEF.md
# Exception Entry Controller

This block performs the architectural register update a processor core makes when it accepts an exception. The core presents a one-cycle `fault_valid` pulse, the kind of fault, the faulting PC, the next PC, and the current Status, Cause and shadow-set control words. On the next clock edge the block registers four results: the new Status word, the new Cause word, the exception PC, and the new shadow-set control word. Each result has its own write-enable pulse. The block also produces a fetch redirect to the handler address.

The block detects a branch delay slot by comparing the next PC with the current PC plus the instruction size. The shadow register sets rotate only while the core is neither already at exception level nor running from boot vectors. The two reset kinds follow a separate path. That path only marks coprocessor 1 usable and vectors to the boot address. The core writes the returned words back into its own registers.

Top module: `exc_entry_ctrl`

## Requirements
- R1: A `fault_valid` sampled high at a rising edge gives `redirect_valid` and the write enables that apply, for exactly one cycle after that edge. A cycle with `fault_valid` low gives no pulse on any of them.
- R2: For every fault kind except reset (12) and soft reset (13), `status_o` equals `status_i` with bit 1 (exception level) forced to 1, and `status_we` pulses.
- R3: An instruction is in a delay slot when `next_pc` differs from `cur_pc + 4`. In that case `epc_o = cur_pc - 4` and Cause bit 31 is 1. Otherwise `epc_o = cur_pc` and bit 31 is 0.
- R4: `cause_o` equals `cause_i` with three changes: bits 29:28 are cleared, bits 6:2 hold the code of the fault kind, and bit 31 follows R3. The codes per kind are: interrupt(0)=0, syscall(1)=8, reserved instruction(2)=10, overflow(3)=12, trap(4)=13, breakpoint(5)=9, machine check(6)=24, coprocessor unusable(7)=11, TLB modified(11)=1. All other kinds use code 0.
- R5: When `status_i` bit 1 and bit 22 are both 0, `srs_we` pulses. `srsctl_o` then holds `srsctl_i` with bits 9:6 taken from bits 3:0, and bits 3:0 taken from bits 15:12. In any other case `srs_we` stays low.
- R6: Reset (12), soft reset (13) and NMI (14) redirect to 0xBFC00000. Every other kind redirects to a base plus an offset. The base is 0xBFC00200 when `status_i` bit 22 is 1 and 0x80000000 when it is 0. The offset is 0x000 for interrupt (0) and 0x180 for all other kinds.
- R7: For reset and soft reset, `status_o` is `status_i` with bit 29 set and `status_we` pulses. `cause_we`, `epc_we` and `srs_we` stay low.
- R8: A low `rst_n` at a rising edge clears every output to zero. This includes the exception-level bit and the shadow-set fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fault_valid | input | 1 | One-cycle exception request |
| fault_kind | input | 4 | Fault kind encoding (see R4, R6) |
| cur_pc | input | 32 | PC of the faulting instruction |
| next_pc | input | 32 | PC that would follow it |
| status_i | input | 32 | Current Status word |
| cause_i | input | 32 | Current Cause word |
| srsctl_i | input | 32 | Current shadow-set control word |
| redirect_valid | output | 1 | Fetch redirect pulse |
| redirect_pc | output | 32 | Handler address |
| status_we | output | 1 | Status write pulse |
| status_o | output | 32 | New Status word |
| cause_we | output | 1 | Cause write pulse |
| cause_o | output | 32 | New Cause word |
| epc_we | output | 1 | Exception PC write pulse |
| epc_o | output | 32 | New exception PC |
| srs_we | output | 1 | Shadow-set control write pulse |
| srsctl_o | output | 32 | New shadow-set control word |

## Verification
Every result of this block is due exactly one rising edge after the cycle that presents `fault_valid`. This holds for the redirect, all four words and their enables. Idle cycles must show all pulses low on that same edge. The driver stamps each expected item with the cycle number in which it falls due. The monitor compares at the falling edge of that cycle only, so both a late pulse and an early pulse show up as mismatches. The reset clear is checked at the falling edge right after the first edge that samples `rst_n` low.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int REG_W = 32;

    typedef enum logic [3:0] {
        FK_INT          = 4'd0,
        FK_SYSCALL      = 4'd1,
        FK_RSVD_INSN    = 4'd2,
        FK_OVERFLOW     = 4'd3,
        FK_TRAP         = 4'd4,
        FK_BREAK        = 4'd5,
        FK_MCHECK       = 4'd6,
        FK_COP_UNUSABLE = 4'd7,
        FK_ADDR_ERR     = 4'd8,
        FK_TLB_INVALID  = 4'd9,
        FK_TLB_REFILL   = 4'd10,
        FK_TLB_MOD      = 4'd11,
        FK_RESET        = 4'd12,
        FK_SOFT_RESET   = 4'd13,
        FK_NMI          = 4'd14,
        FK_THREAD       = 4'd15
    } fault_kind_e;

    // Status word fields
    localparam int ST_EXL_BIT = 1;
    localparam int ST_BEV_BIT = 22;
    localparam int ST_CU1_BIT = 29;

    // Cause word fields
    localparam int CA_BD_BIT   = 31;
    localparam int CA_CE_LSB   = 28;
    localparam int CA_CE_W     = 2;
    localparam int CA_CODE_LSB = 2;
    localparam int CA_CODE_W   = 5;

    // Shadow-set control fields
    localparam int SRS_CUR_LSB  = 0;
    localparam int SRS_PREV_LSB = 6;
    localparam int SRS_EXC_LSB  = 12;
    localparam int SRS_FLD_W    = 4;

    // Exception codes
    localparam logic [CA_CODE_W-1:0] XC_INT    = 5'd0;
    localparam logic [CA_CODE_W-1:0] XC_MOD    = 5'd1;
    localparam logic [CA_CODE_W-1:0] XC_SYS    = 5'd8;
    localparam logic [CA_CODE_W-1:0] XC_BP     = 5'd9;
    localparam logic [CA_CODE_W-1:0] XC_RI     = 5'd10;
    localparam logic [CA_CODE_W-1:0] XC_CPU    = 5'd11;
    localparam logic [CA_CODE_W-1:0] XC_OV     = 5'd12;
    localparam logic [CA_CODE_W-1:0] XC_TR     = 5'd13;
    localparam logic [CA_CODE_W-1:0] XC_MCHECK = 5'd24;
    localparam logic [CA_CODE_W-1:0] XC_NONE   = 5'd0;

endpackage

// File: rtl/exc_code_map.sv
module exc_code_map
    import exc_entry_pkg::*;
(
    input  fault_kind_e               kind,
    output logic [CA_CODE_W-1:0]      code,
    output logic                      reset_class,
    output logic                      boot_vector,
    output logic                      low_offset
);

    always_comb begin
        unique case (kind)
            FK_INT:          code = XC_INT;
            FK_SYSCALL:      code = XC_SYS;
            FK_RSVD_INSN:    code = XC_RI;
            FK_OVERFLOW:     code = XC_OV;
            FK_TRAP:         code = XC_TR;
            FK_BREAK:        code = XC_BP;
            FK_MCHECK:       code = XC_MCHECK;
            FK_COP_UNUSABLE: code = XC_CPU;
            FK_TLB_MOD:      code = XC_MOD;
            default:         code = XC_NONE;
        endcase
    end

    assign reset_class = (kind == FK_RESET) || (kind == FK_SOFT_RESET);
    assign boot_vector = reset_class || (kind == FK_NMI);
    assign low_offset  = boot_vector || (kind == FK_INT);

endmodule

// File: rtl/exc_slot_detect.sv
module exc_slot_detect #(
    parameter int XLEN       = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] npc,
    output logic            in_slot,
    output logic [XLEN-1:0] epc_val
);

    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    logic [XLEN-1:0] seq_pc;

    assign seq_pc  = pc + STEP;
    assign in_slot = (npc != seq_pc);
    assign epc_val = in_slot ? (pc - STEP) : pc;

endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel #(
    parameter int              XLEN        = 32,
    parameter logic [XLEN-1:0] BOOT_BASE   = 32'hBFC0_0000,
    parameter logic [XLEN-1:0] BEV_BASE    = 32'hBFC0_0200,
    parameter logic [XLEN-1:0] NORM_BASE   = 32'h8000_0000,
    parameter logic [XLEN-1:0] GEN_OFFSET  = 32'h0000_0180
) (
    input  logic            bev,
    input  logic            boot_vector,
    input  logic            low_offset,
    output logic [XLEN-1:0] vector
);

    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;

    always_comb begin
        if (boot_vector)
            base = BOOT_BASE;
        else if (bev)
            base = BEV_BASE;
        else
            base = NORM_BASE;
        offset = low_offset ? '0 : GEN_OFFSET;
        vector = base + offset;
    end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int              XLEN       = 32,
    parameter int              INSN_BYTES = 4,
    parameter logic [XLEN-1:0] BOOT_BASE  = 32'hBFC0_0000,
    parameter logic [XLEN-1:0] BEV_BASE   = 32'hBFC0_0200,
    parameter logic [XLEN-1:0] NORM_BASE  = 32'h8000_0000,
    parameter logic [XLEN-1:0] GEN_OFFSET = 32'h0000_0180
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fault_valid,
    input  logic [3:0]       fault_kind,
    input  logic [XLEN-1:0]  cur_pc,
    input  logic [XLEN-1:0]  next_pc,
    input  logic [REG_W-1:0] status_i,
    input  logic [REG_W-1:0] cause_i,
    input  logic [REG_W-1:0] srsctl_i,
    output logic             redirect_valid,
    output logic [XLEN-1:0]  redirect_pc,
    output logic             status_we,
    output logic [REG_W-1:0] status_o,
    output logic             cause_we,
    output logic [REG_W-1:0] cause_o,
    output logic             epc_we,
    output logic [XLEN-1:0]  epc_o,
    output logic             srs_we,
    output logic [REG_W-1:0] srsctl_o
);

    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    typedef struct packed {
        logic             redir_v;
        logic [XLEN-1:0]  redir_pc;
        logic             st_we;
        logic [REG_W-1:0] st;
        logic             ca_we;
        logic [REG_W-1:0] ca;
        logic             epc_we;
        logic [XLEN-1:0]  epc;
        logic             srs_we;
        logic [REG_W-1:0] srs;
    } entry_t;

    entry_t state_d, state_q;

    fault_kind_e           kind;
    logic [CA_CODE_W-1:0]  code;
    logic                  reset_class;
    logic                  boot_vector;
    logic                  low_offset;
    logic                  in_slot;
    logic [XLEN-1:0]       epc_val;
    logic [XLEN-1:0]       vector;

    assign kind = fault_kind_e'(fault_kind);

    exc_code_map u_code (
        .kind        (kind),
        .code        (code),
        .reset_class (reset_class),
        .boot_vector (boot_vector),
        .low_offset  (low_offset)
    );

    exc_slot_detect #(
        .XLEN       (XLEN),
        .INSN_BYTES (INSN_BYTES)
    ) u_slot (
        .pc      (cur_pc),
        .npc     (next_pc),
        .in_slot (in_slot),
        .epc_val (epc_val)
    );

    exc_vector_sel #(
        .XLEN       (XLEN),
        .BOOT_BASE  (BOOT_BASE),
        .BEV_BASE   (BEV_BASE),
        .NORM_BASE  (NORM_BASE),
        .GEN_OFFSET (GEN_OFFSET)
    ) u_vec (
        .bev         (status_i[ST_BEV_BIT]),
        .boot_vector (boot_vector),
        .low_offset  (low_offset),
        .vector      (vector)
    );

    always_comb begin
        state_d         = state_q;
        state_d.redir_v = 1'b0;
        state_d.st_we   = 1'b0;
        state_d.ca_we   = 1'b0;
        state_d.epc_we  = 1'b0;
        state_d.srs_we  = 1'b0;
        if (fault_valid) begin
            state_d.redir_v  = 1'b1;
            state_d.redir_pc = vector;
            state_d.st_we    = 1'b1;
            if (reset_class) begin
                state_d.st             = status_i;
                state_d.st[ST_CU1_BIT] = 1'b1;
            end else begin
                state_d.st             = status_i;
                state_d.st[ST_EXL_BIT] = 1'b1;

                state_d.ca                               = cause_i;
                state_d.ca[CA_BD_BIT]                    = in_slot;
                state_d.ca[CA_CE_LSB +: CA_CE_W]         = '0;
                state_d.ca[CA_CODE_LSB +: CA_CODE_W]     = code;
                state_d.ca_we                            = 1'b1;

                state_d.epc    = epc_val;
                state_d.epc_we = 1'b1;

                if (!status_i[ST_EXL_BIT] && !status_i[ST_BEV_BIT]) begin
                    state_d.srs = srsctl_i;
                    state_d.srs[SRS_PREV_LSB +: SRS_FLD_W] = srsctl_i[SRS_CUR_LSB +: SRS_FLD_W];
                    state_d.srs[SRS_CUR_LSB  +: SRS_FLD_W] = srsctl_i[SRS_EXC_LSB +: SRS_FLD_W];
                    state_d.srs_we = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign redirect_valid = state_q.redir_v;
    assign redirect_pc    = state_q.redir_pc;
    assign status_we      = state_q.st_we;
    assign status_o       = state_q.st;
    assign cause_we       = state_q.ca_we;
    assign cause_o        = state_q.ca;
    assign epc_we         = state_q.epc_we;
    assign epc_o          = state_q.epc;
    assign srs_we         = state_q.srs_we;
    assign srsctl_o       = state_q.srs;

    // ---------------- assertions ----------------
    p_redirect_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && fault_valid) |=> redirect_valid);

    p_quiet_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !fault_valid) |=> (!redirect_valid && !status_we && !cause_we && !epc_we && !srs_we));

    p_exl_on_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        epc_we |-> (status_we && status_o[ST_EXL_BIT]));

    p_epc_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
        epc_we |-> (epc_o == (cause_o[CA_BD_BIT] ? ($past(cur_pc) - STEP) : $past(cur_pc))));

    p_ce_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cause_we |-> (cause_o[CA_CE_LSB +: CA_CE_W] == '0));

    p_srs_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        srs_we |-> (!$past(status_i[ST_EXL_BIT]) && !$past(status_i[ST_BEV_BIT])));

    p_boot_vector_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid && !epc_we) |-> (redirect_pc == BOOT_BASE));

    p_reset_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_we && !cause_we) |-> (status_o[ST_CU1_BIT] && !epc_we && !srs_we));

endmodule

// File: tb/exc_entry_ctrl_test.sv
`timescale 1ns/1ps
module exc_entry_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fault_valid = 1'b0;
    logic [3:0]  fault_kind = '0;
    logic [31:0] cur_pc = '0, next_pc = '0, status_i = '0, cause_i = '0, srsctl_i = '0;
    logic        redirect_valid, status_we, cause_we, epc_we, srs_we;
    logic [31:0] redirect_pc, status_o, cause_o, epc_o, srsctl_o;

    always #10 clk = ~clk;

    exc_entry_ctrl uut (
        .clk(clk), .rst_n(rst_n), .fault_valid(fault_valid), .fault_kind(fault_kind),
        .cur_pc(cur_pc), .next_pc(next_pc), .status_i(status_i), .cause_i(cause_i),
        .srsctl_i(srsctl_i), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .status_we(status_we), .status_o(status_o), .cause_we(cause_we), .cause_o(cause_o),
        .epc_we(epc_we), .epc_o(epc_o), .srs_we(srs_we), .srsctl_o(srsctl_o)
    );

    typedef struct {
        int          due;
        bit          act;
        string       tag;
        logic [31:0] vec, st, ca, epc, srs;
        bit          st_we, ca_we, epc_we, srs_we;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input string fld, input logic [31:0] a, input logic [31:0] e);
        n_cmp++;
        if (a !== e) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, fld, a, e);
        end
    endtask

    function automatic logic [4:0] code_of(input logic [3:0] k);
        case (k)
            4'd0:  return 5'd0;
            4'd1:  return 5'd8;
            4'd2:  return 5'd10;
            4'd3:  return 5'd12;
            4'd4:  return 5'd13;
            4'd5:  return 5'd9;
            4'd6:  return 5'd24;
            4'd7:  return 5'd11;
            4'd11: return 5'd1;
            default: return 5'd0;
        endcase
    endfunction

    task automatic drive(input bit v, input logic [3:0] k, input logic [31:0] pc, input logic [31:0] npc,
                         input logic [31:0] st, input logic [31:0] ca, input logic [31:0] srs, input string tag);
        exp_t e;
        bit boot, low, rstk, slot;
        @(negedge clk);
        fault_valid = v; fault_kind = k; cur_pc = pc; next_pc = npc;
        status_i = st; cause_i = ca; srsctl_i = srs;
        e = '{default: '0};
        e.due = cyc + 1; e.act = v; e.tag = tag;
        if (v) begin
            rstk = (k == 4'd12) || (k == 4'd13);
            boot = rstk || (k == 4'd14);
            low  = boot || (k == 4'd0);
            e.vec = (boot ? 32'hBFC0_0000 : (st[22] ? 32'hBFC0_0200 : 32'h8000_0000)) + (low ? 32'h0 : 32'h180);
            e.st_we = 1'b1;
            if (rstk) begin
                e.st = st | 32'h2000_0000;
            end else begin
                slot = (npc != pc + 32'd4);
                e.st = st | 32'h0000_0002;
                e.ca = ca; e.ca[31] = slot; e.ca[29:28] = 2'b00; e.ca[6:2] = code_of(k);
                e.ca_we = 1'b1;
                e.epc = slot ? pc - 32'd4 : pc; e.epc_we = 1'b1;
                if (!st[1] && !st[22]) begin
                    e.srs = srs; e.srs[9:6] = srs[3:0]; e.srs[3:0] = srs[15:12]; e.srs_we = 1'b1;
                end
            end
        end
        q.push_back(e);
    endtask

    task automatic idle(input string tag);
        drive(1'b0, 4'd0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, tag);
    endtask

    // monitor: compares each item in the cycle it is due
    always @(negedge clk) begin
        if (q.size() > 0 && q[0].due == cyc) begin
            exp_t e;
            e = q.pop_front();
            chk(e.tag, "redirect_valid", {31'd0, redirect_valid}, {31'd0, e.act});
            chk(e.tag, "status_we", {31'd0, status_we}, {31'd0, e.st_we});
            chk(e.tag, "cause_we",  {31'd0, cause_we},  {31'd0, e.ca_we});
            chk(e.tag, "epc_we",    {31'd0, epc_we},    {31'd0, e.epc_we});
            chk(e.tag, "srs_we",    {31'd0, srs_we},    {31'd0, e.srs_we});
            if (e.act)    chk(e.tag, "redirect_pc", redirect_pc, e.vec);
            if (e.st_we)  chk(e.tag, "status_o", status_o, e.st);
            if (e.ca_we)  chk(e.tag, "cause_o", cause_o, e.ca);
            if (e.epc_we) chk(e.tag, "epc_o", epc_o, e.epc);
            if (e.srs_we) chk(e.tag, "srsctl_o", srsctl_o, e.srs);
        end
    end

    task automatic check_cleared(input string tag);
        chk(tag, "redirect_valid", {31'd0, redirect_valid}, 32'd0);
        chk(tag, "redirect_pc", redirect_pc, 32'd0);
        chk(tag, "status_o", status_o, 32'd0);
        chk(tag, "cause_o", cause_o, 32'd0);
        chk(tag, "epc_o", epc_o, 32'd0);
        chk(tag, "srsctl_o", srsctl_o, 32'd0);
        chk(tag, "enables", {28'd0, status_we, cause_we, epc_we, srs_we}, 32'd0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_cleared("R8 reset");
        rst_n = 1'b1;

        idle("R1 idle");
        // every kind, normal mode, sequential flow: R2 R4 R5 R6 R7
        for (int k = 0; k < 16; k++)
            drive(1'b1, 4'(k), 32'h0000_1000 + 32'(k) * 32'h10, 32'h0000_1004 + 32'(k) * 32'h10,
                  32'h0000_FF00, 32'h3000_0000 | 32'h0000_4400, 32'h0000_5002, "R2/R4/R5/R6/R7 kind sweep");
        idle("R1 idle after burst");
        // delay slot cases: R3
        drive(1'b1, 4'd1, 32'h0000_2000, 32'h0000_3000, 32'h0, 32'h0, 32'h0000_A003, "R3 branch slot");
        drive(1'b1, 4'd3, 32'h0000_2100, 32'h0000_2100, 32'h0, 32'h8000_007C, 32'h0, "R3 npc equals pc");
        drive(1'b1, 4'd4, 32'h0000_2200, 32'h0000_2204, 32'h0, 32'h8000_0000, 32'h0, "R3 no slot clears BD");
        // EXL already set: no shadow update, R5
        drive(1'b1, 4'd5, 32'h0000_3000, 32'h0000_3004, 32'h0000_0002, 32'h0, 32'h0000_7001, "R5 exl set");
        // BEV set: R5 and R6
        drive(1'b1, 4'd2, 32'h0000_3100, 32'h0000_3104, 32'h0040_0000, 32'h0, 32'h0000_7001, "R5/R6 bev general");
        drive(1'b1, 4'd0, 32'h0000_3200, 32'h0000_3204, 32'h0040_0000, 32'h0, 32'h0, "R6 bev interrupt");
        drive(1'b1, 4'd14, 32'h0000_3300, 32'h0000_3304, 32'h0040_0000, 32'h0, 32'h0, "R6 bev nmi");
        drive(1'b1, 4'd12, 32'h0000_3400, 32'h0000_3500, 32'h0040_0002, 32'hFFFF_FFFF, 32'hFFFF, "R7 reset with bev");
        idle("R1 idle");
        idle("R1 idle");
        drive(1'b1, 4'd11, 32'h0000_4000, 32'h0000_4004, 32'h0, 32'hFFFF_FFFF, 32'h0000_F00F, "R4 tlb mod keeps bits");

        wait (q.size() == 0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_cleared("R8 mid-run reset");
        rst_n = 1'b1;
        drive(1'b1, 4'd6, 32'h0000_5000, 32'h0000_5004, 32'h0, 32'h0, 32'h0000_3000, "R1 after reset");
        idle("R1 final idle");
        wait (q.size() == 0);
        @(negedge clk);
        finish_run();
    end

endmodule